// File: doc/BRIEF.md
# Dual-Clock Resettable Line Memory

This block is a line buffer built from a word array with two fully independent ports. The write port has its own clock, an active-low enable and an active-low pointer restart; the read port has the same three controls on its own clock. Each port walks the array with its own address counter that wraps at the end of the line. There is no occupancy tracking at all: the relation between the two counters is set entirely by when the user restarts each one. That makes the block a programmable delay line rather than a flow-controlled queue.

In the typical use both enables stay low and both restarts are pulsed together, which delays the input stream by one full line (`2**ADDR_W` words). A shorter delay of n words is obtained by restarting the read pointer n write cycles after the write pointer, or by holding the read enable high for n read cycles. The read output models a three-state bus as a data vector plus an output-valid flag. The default depth parameter gives 2048 words; setting `ADDR_W` to 13 gives an 8192-word line of 8-bit words.

Top module: `line_mem`

## Requirements
- R1: The array holds `2**ADDR_W` words of `DATA_W` bits and both address counters wrap modulo `2**ADDR_W`; after a write restart followed by `2**ADDR_W + k` stored words, addresses 0 to k-1 hold the last k words and address k onward still hold the first lap.
- R2: With `wr_rst_n` high and `wr_en_n` low, a rising `wr_clk` edge stores `wr_data` at the write counter and advances the counter by one.
- R3: With `wr_rst_n` high and `wr_en_n` high, a rising `wr_clk` edge stores nothing and the write counter keeps its value.
- R4: `wr_rst_n` low takes priority over the enable: with `wr_en_n` high the write counter becomes 0 and nothing is stored; with `wr_en_n` low the word on `wr_data` is stored at address 0 and the counter becomes 1.
- R5: With `rd_rst_n` high and `rd_en_n` low, a rising `rd_clk` edge presents the word at the read counter on `rd_data` with `rd_oe` = 1 from that edge on, and advances the counter by one.
- R6: With `rd_en_n` high, a rising `rd_clk` edge drives `rd_oe` to 0 and, when `IDLE_ZERO` = 1 (default), `rd_data` to all zeros; with `rd_rst_n` also high the read counter keeps its value, so the next enabled read continues at the following address.
- R7: `rd_rst_n` low takes priority over the enable: with `rd_en_n` low word 0 is presented at that edge and the counter becomes 1; with `rd_en_n` high the counter becomes 0 and the next enabled read returns word 0.
- R8: Restarting the read pointer after n words have been stored since a write restart yields the written stream delayed by n words, with no word lost or repeated across idle cycles on either port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write port clock |
| wr_en_n | input | 1 | Write enable, active low |
| wr_rst_n | input | 1 | Write pointer restart, active low |
| wr_data | input | DATA_W | Word to store |
| rd_clk | input | 1 | Read port clock |
| rd_en_n | input | 1 | Read enable, active low |
| rd_rst_n | input | 1 | Read pointer restart, active low |
| rd_data | output | DATA_W | Word read from the array (zero while idle by default) |
| rd_oe | output | 1 | High when `rd_data` carries a driven word, low for the high-impedance state |

## Verification
The assertions follow both counters on every edge of their own clock: step, hold, clear and restart-with-access (R2 to R7), together with the output-valid flag and idle zeroing on the read side. What they cannot see is the content of the array, so wrap-around of the line (R1), storage at address 0 during a restart, skipping of idle write cycles and the end-to-end delay (R8) are shown only by the bench scenarios, which run the two ports on unrelated clocks and compare every read word against an expected array built from the requirements.

// File: rtl/lm_pkg.sv
`timescale 1ns/1ps
package lm_pkg;

   // Per-edge action of one address counter.
   typedef enum logic [1:0] {
      PTR_HOLD    = 2'd0,   // port idle, counter kept
      PTR_STEP    = 2'd1,   // access at counter, counter + 1
      PTR_CLEAR   = 2'd2,   // restart without access, counter to 0
      PTR_RESTART = 2'd3    // restart with access at 0, counter to 1
   } ptr_op_e;

   // Restart outranks enable; both inputs are active low.
   function automatic ptr_op_e decode_op(input logic rst_n, input logic en_n);
      ptr_op_e op;
      if (!rst_n) op = en_n ? PTR_CLEAR : PTR_RESTART;
      else        op = en_n ? PTR_HOLD  : PTR_STEP;
      return op;
   endfunction

endpackage

// File: rtl/lm_ptr.sv
`timescale 1ns/1ps
// Address counter for one port of the line memory.
module lm_ptr #(
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              en_n,
   input  logic              rst_n,
   output logic              access,
   output logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] ptr
);
   import lm_pkg::*;

   ptr_op_e op;

   always_comb begin
      op     = decode_op(rst_n, en_n);
      access = (op == PTR_STEP) || (op == PTR_RESTART);
      addr   = (op == PTR_RESTART) ? '0 : ptr;
   end

   always_ff @(posedge clk) begin
      unique case (op)
         PTR_HOLD:  ptr <= ptr;
         PTR_CLEAR: ptr <= '0;
         default:   ptr <= addr + 1'b1;
      endcase
   end

endmodule

// File: rtl/lm_store.sv
`timescale 1ns/1ps
// Word array with one write port and one registered read port,
// each on its own clock.
module lm_store #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 11
) (
   input  logic              wclk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rclk,
   input  logic              re,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rword
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) mem[waddr] <= wdata;
   end

   // Read register holds its word while the port is idle.
   always_ff @(posedge rclk) begin
      if (re) rword <= mem[raddr];
   end

endmodule

// File: rtl/lm_out_stage.sv
`timescale 1ns/1ps
// Output-valid flag and idle gating of the read bus.
module lm_out_stage #(
   parameter int DATA_W    = 8,
   parameter bit IDLE_ZERO = 1'b1
) (
   input  logic              clk,
   input  logic              en_n,
   input  logic [DATA_W-1:0] word,
   output logic [DATA_W-1:0] data,
   output logic              oe
);
   always_ff @(posedge clk) begin
      oe <= !en_n;
   end

   generate
      if (IDLE_ZERO) begin : g_idle_zero
         assign data = oe ? word : '0;
      end else begin : g_idle_hold
         assign data = word;
      end
   endgenerate

endmodule

// File: rtl/line_mem.sv
`timescale 1ns/1ps
// Dual-clock line memory used as a programmable delay line.
module line_mem #(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 11,
   parameter bit IDLE_ZERO = 1'b1
) (
   input  logic              wr_clk,
   input  logic              wr_en_n,
   input  logic              wr_rst_n,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_clk,
   input  logic              rd_en_n,
   input  logic              rd_rst_n,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_oe
);
   generate
      if (DATA_W < 1) begin : g_bad_data_w
         $error("line_mem: DATA_W must be at least 1");
      end
      if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_addr_w
         $error("line_mem: ADDR_W must lie between 2 and 16");
      end
   endgenerate

   logic              wr_access;
   logic [ADDR_W-1:0] wr_addr;
   logic [ADDR_W-1:0] wr_ptr;
   logic              rd_access;
   logic [ADDR_W-1:0] rd_addr;
   logic [ADDR_W-1:0] rd_ptr;
   logic [DATA_W-1:0] rd_word;

   lm_ptr #(.ADDR_W(ADDR_W)) u_wr_ptr (
      .clk    (wr_clk),
      .en_n   (wr_en_n),
      .rst_n  (wr_rst_n),
      .access (wr_access),
      .addr   (wr_addr),
      .ptr    (wr_ptr)
   );

   lm_ptr #(.ADDR_W(ADDR_W)) u_rd_ptr (
      .clk    (rd_clk),
      .en_n   (rd_en_n),
      .rst_n  (rd_rst_n),
      .access (rd_access),
      .addr   (rd_addr),
      .ptr    (rd_ptr)
   );

   lm_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
      .wclk  (wr_clk),
      .we    (wr_access),
      .waddr (wr_addr),
      .wdata (wr_data),
      .rclk  (rd_clk),
      .re    (rd_access),
      .raddr (rd_addr),
      .rword (rd_word)
   );

   lm_out_stage #(.DATA_W(DATA_W), .IDLE_ZERO(IDLE_ZERO)) u_out (
      .clk  (rd_clk),
      .en_n (rd_en_n),
      .word (rd_word),
      .data (rd_data),
      .oe   (rd_oe)
   );

endmodule

// File: rtl/lm_checker.sv
`timescale 1ns/1ps
// Counter and output-flag properties, bound into line_mem.
module lm_checker #(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 11,
   parameter bit IDLE_ZERO = 1'b1
) (
   input logic              wr_clk,
   input logic              wr_en_n,
   input logic              wr_rst_n,
   input logic [ADDR_W-1:0] wr_ptr,
   input logic              rd_clk,
   input logic              rd_en_n,
   input logic              rd_rst_n,
   input logic [ADDR_W-1:0] rd_ptr,
   input logic [DATA_W-1:0] rd_data,
   input logic              rd_oe
);
   // Counters carry no value until their first restart.
   logic w_armed = 1'b0;
   logic r_armed = 1'b0;

   always_ff @(posedge wr_clk) if (!wr_rst_n) w_armed <= 1'b1;
   always_ff @(posedge rd_clk) if (!rd_rst_n) r_armed <= 1'b1;

   a_r2_wr_step: assert property (@(posedge wr_clk) disable iff (!w_armed)
      (wr_rst_n && !wr_en_n) |=> wr_ptr == ADDR_W'($past(wr_ptr) + 1'b1))
      else $error("a_r2_wr_step");

   a_r3_wr_hold: assert property (@(posedge wr_clk) disable iff (!w_armed)
      (wr_rst_n && wr_en_n) |=> $stable(wr_ptr))
      else $error("a_r3_wr_hold");

   a_r4_wr_clear: assert property (@(posedge wr_clk) disable iff (!w_armed)
      (!wr_rst_n && wr_en_n) |=> wr_ptr == '0)
      else $error("a_r4_wr_clear");

   a_r4_wr_restart: assert property (@(posedge wr_clk) disable iff (!w_armed)
      (!wr_rst_n && !wr_en_n) |=> wr_ptr == ADDR_W'(1))
      else $error("a_r4_wr_restart");

   a_r5_rd_step: assert property (@(posedge rd_clk) disable iff (!r_armed)
      (rd_rst_n && !rd_en_n) |=> rd_oe && rd_ptr == ADDR_W'($past(rd_ptr) + 1'b1))
      else $error("a_r5_rd_step");

   a_r6_rd_idle: assert property (@(posedge rd_clk) disable iff (!r_armed)
      rd_en_n |=> !rd_oe && (!IDLE_ZERO || rd_data == '0))
      else $error("a_r6_rd_idle");

   a_r6_rd_hold: assert property (@(posedge rd_clk) disable iff (!r_armed)
      (rd_rst_n && rd_en_n) |=> $stable(rd_ptr))
      else $error("a_r6_rd_hold");

   a_r7_rd_clear: assert property (@(posedge rd_clk) disable iff (!r_armed)
      (!rd_rst_n && rd_en_n) |=> rd_ptr == '0)
      else $error("a_r7_rd_clear");

   a_r7_rd_restart: assert property (@(posedge rd_clk) disable iff (!r_armed)
      (!rd_rst_n && !rd_en_n) |=> rd_oe && rd_ptr == ADDR_W'(1))
      else $error("a_r7_rd_restart");

endmodule

bind line_mem lm_checker #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDLE_ZERO(IDLE_ZERO)
) u_lm_checker (
   .wr_clk   (wr_clk),
   .wr_en_n  (wr_en_n),
   .wr_rst_n (wr_rst_n),
   .wr_ptr   (wr_ptr),
   .rd_clk   (rd_clk),
   .rd_en_n  (rd_en_n),
   .rd_rst_n (rd_rst_n),
   .rd_ptr   (rd_ptr),
   .rd_data  (rd_data),
   .rd_oe    (rd_oe)
);

// File: tb/line_mem_bench.sv
`timescale 1ns/1ps
module line_mem_bench;
   localparam int DW    = 8;
   localparam int AW    = 8;
   localparam int DEPTH = 1 << AW;

   // Stream cases: words, lag before read restart, seed,
   // write idle period, read idle period (0 = none).
   localparam int NCASE = 4;
   localparam int CASES [NCASE][5] = '{
      '{ 40,  2,  3, 0, 0},
      '{ 60, 10,  7, 4, 0},
      '{ 50,  5, 11, 0, 3},
      '{100, 30, 19, 5, 4}
   };

   logic          wr_clk = 1'b0;
   logic          rd_clk = 1'b0;
   logic          wr_en_n = 1'b1;
   logic          wr_rst_n = 1'b1;
   logic [DW-1:0] wr_data = '0;
   logic          rd_en_n = 1'b1;
   logic          rd_rst_n = 1'b1;
   logic [DW-1:0] rd_data;
   logic          rd_oe;

   always #4   wr_clk = ~wr_clk;   // 125 MHz
   always #6.5 rd_clk = ~rd_clk;   // unrelated read clock

   line_mem #(.DATA_W(DW), .ADDR_W(AW)) u_line_mem (
      .wr_clk(wr_clk), .wr_en_n(wr_en_n), .wr_rst_n(wr_rst_n), .wr_data(wr_data),
      .rd_clk(rd_clk), .rd_en_n(rd_en_n), .rd_rst_n(rd_rst_n),
      .rd_data(rd_data), .rd_oe(rd_oe)
   );

   int n_chk = 0;
   int n_fail = 0;
   int wr_done = 0;
   int mwa = 0;
   int mra = 0;
   logic [DW-1:0] exp_mem [DEPTH];

   function automatic logic [DW-1:0] dat(input int s, input int i);
      return DW'((s * 37) ^ (i * 13) ^ ((i >> AW) * 85));
   endfunction

   task automatic check(input string tag, input logic [DW:0] act, input logic [DW:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s actual oe/data=%h expected=%h", tag, act, expv);
      end
   endtask

   // Called at a write-clock falling edge; returns at the next one.
   task automatic wcyc(input logic en_n, input logic rst_n, input logic [DW-1:0] d);
      int a;
      wr_en_n = en_n; wr_rst_n = rst_n; wr_data = d;
      @(posedge wr_clk);
      a = rst_n ? mwa : 0;
      if (!en_n) begin
         exp_mem[a] = d;
         mwa = (a + 1) % DEPTH;
      end else begin
         mwa = a;
      end
      @(negedge wr_clk);
   endtask

   // Called at a read-clock falling edge; checks the bus at the next one.
   task automatic rcyc(input logic en_n, input logic rst_n, input string tag);
      int a;
      logic [DW-1:0] e;
      e = '0;
      rd_en_n = en_n; rd_rst_n = rst_n;
      @(posedge rd_clk);
      a = rst_n ? mra : 0;
      if (!en_n) begin
         e = exp_mem[a];
         mra = (a + 1) % DEPTH;
      end else begin
         mra = a;
      end
      @(negedge rd_clk);
      if (!en_n) check(tag, {rd_oe, rd_data}, {1'b1, e});
      else       check(tag, {rd_oe, rd_data}, {1'b0, {DW{1'b0}}});
   endtask

   task automatic report;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #1_000_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      // Reset state: both pointers cleared with ports idle (R6, R4, R7).
      @(negedge wr_clk);
      wcyc(1'b1, 1'b0, '0);
      wcyc(1'b1, 1'b1, '0);
      @(negedge rd_clk);
      rcyc(1'b1, 1'b0, "R6 reset state");
      rcyc(1'b1, 1'b1, "R6 idle");

      // Vector table: delayed streams on unrelated clocks (R2 R3 R5 R6 R8).
      for (int c = 0; c < NCASE; c++) begin
         wr_done = 0;
         fork
            begin : writer
               int k;
               @(negedge wr_clk);
               wcyc(1'b0, 1'b0, dat(CASES[c][2], 0));
               wr_done = 1;
               k = 1;
               while (wr_done < CASES[c][0]) begin
                  if (CASES[c][3] != 0 && k % CASES[c][3] == 0)
                     wcyc(1'b1, 1'b1, 8'hEE);
                  else begin
                     wcyc(1'b0, 1'b1, dat(CASES[c][2], wr_done));
                     wr_done++;
                  end
                  k++;
               end
               wcyc(1'b1, 1'b1, '0);
            end
            begin : reader
               int got;
               int k;
               wait (wr_done >= CASES[c][1]);
               @(negedge rd_clk);
               rcyc(1'b0, 1'b0, "R8 delayed stream start");
               got = 1;
               k = 1;
               while (got < CASES[c][0]) begin
                  if (CASES[c][4] != 0 && k % CASES[c][4] == 0)
                     rcyc(1'b1, 1'b1, "R6 read pause");
                  else begin
                     rcyc(1'b0, 1'b1, "R2/R3/R5/R8 stream word");
                     got++;
                  end
                  k++;
               end
               rcyc(1'b1, 1'b1, "R6 stream end");
            end
         join
      end

      // R1: more than one line written, first addresses overwritten.
      @(negedge wr_clk);
      wcyc(1'b0, 1'b0, dat(1, 0));
      for (int i = 1; i < DEPTH + 5; i++) wcyc(1'b0, 1'b1, dat(1, i));
      wcyc(1'b1, 1'b1, '0);
      @(negedge rd_clk);
      rcyc(1'b0, 1'b0, "R1 wrapped word 0");
      for (int i = 1; i < 8; i++) rcyc(1'b0, 1'b1, "R1 wrap boundary");

      // R4 and R3: clear without access, then stores from address 0,
      // an idle write in between is not stored.
      @(negedge wr_clk);
      wcyc(1'b1, 1'b0, 8'h55);
      wcyc(1'b0, 1'b1, 8'hA1);
      wcyc(1'b0, 1'b1, 8'hA2);
      wcyc(1'b1, 1'b1, 8'hFF);
      wcyc(1'b0, 1'b1, 8'hA3);
      wcyc(1'b1, 1'b1, '0);

      // R7: clear without access, next read returns word 0.
      @(negedge rd_clk);
      rcyc(1'b1, 1'b0, "R7 clear idle");
      rcyc(1'b0, 1'b1, "R4 word at address 0");
      rcyc(1'b0, 1'b1, "R2 second word");
      rcyc(1'b0, 1'b1, "R3 idle write skipped");
      rcyc(1'b1, 1'b1, "R6 pause");
      rcyc(1'b0, 1'b1, "R6 resume after pause");
      rcyc(1'b0, 1'b0, "R7 restart with read");
      rcyc(1'b0, 1'b1, "R7 follow-on word");
      rcyc(1'b1, 1'b1, "R6 final idle");

      report();
   end

endmodule